// File: doc/BRIEF.md
# Dual-Loop Pilot Presence Decision Sequencer

This block runs the control side of a coarse pilot detector built from two frequency tracking loops. It presets one loop just above a known pilot frequency and the other just below it. It does this once when reset ends and again at the start of every observation period. At the end of each period it compares where the two loops have settled. Frequencies, offsets and the threshold are all given as NCO phase-increment values, scaled as increment = f·2^INC_W / Fclk.

When a pilot is present, both loops are drawn onto the same spectral line, so their increments meet. When no pilot is present, each loop stays at its preset, and the two remain twice the offset apart. The verdict is "present" when the loops are closer than the threshold. Neither loop has to reach the pilot exactly. The verdict is registered and comes with a one-cycle valid pulse. It holds its value until the next period closes.

The observation period is a programmable count of clock cycles. Software sets it to cover somewhere between 30 ms and 100 ms. The tracking loops themselves lie outside this block.

Top module: `pilot_conv_sequencer`

## Requirements
- R1: `init_inc_hi` always equals (`cfg_pilot_inc` + `cfg_offset_inc`) modulo 2^INC_W.
- R2: `init_inc_lo` always equals (`cfg_pilot_inc` − `cfg_offset_inc`) modulo 2^INC_W.
- R3: `preset` is high for exactly one cycle. It is high in the first cycle after reset is released, and again in the first cycle of every later period.
- R4: A period lasts N cycles, where N is the value of `cfg_period` in the preset cycle. Values 0 and 1 are treated as 2.
- R5: A change to `cfg_period` after the preset cycle does not change the length of the current period.
- R6: In the last cycle of a period, the block samples `loop_hi_inc` and `loop_lo_inc` as unsigned values. `detect` becomes 1 when |hi − lo| < `cfg_thresh`. The difference is exact, with no modular wrap.
- R7: The comparison is strict. A difference equal to the threshold gives 0, and a threshold of 0 never gives a detection.
- R8: `detect_valid` is a one-cycle pulse. It comes in the cycle after the last cycle of a period, which is the same cycle as the next `preset`.
- R9: `detect` changes only in a cycle where `detect_valid` is high. Between period ends it holds its value.
- R10: While `rst_n` is low, `preset`, `detect_valid` and `detect` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_pilot_inc | input | INC_W | Nominal pilot as a phase increment |
| cfg_offset_inc | input | INC_W | Preset offset either side of the pilot, as an increment |
| cfg_thresh | input | INC_W | Convergence threshold, as an increment |
| cfg_period | input | CNT_W | Observation period in clock cycles |
| loop_hi_inc | input | INC_W | Present increment of the loop preset above the pilot |
| loop_lo_inc | input | INC_W | Present increment of the loop preset below the pilot |
| preset | output | 1 | One-cycle strobe that loads the initial increments into the loops |
| init_inc_hi | output | INC_W | Initial increment for the upper loop |
| init_inc_lo | output | INC_W | Initial increment for the lower loop |
| detect | output | 1 | Pilot-present verdict from the last period |
| detect_valid | output | 1 | One-cycle pulse marking a new verdict |

## Verification
The bench drives a difference exactly equal to the threshold and a threshold of zero. A design that used `<=` would report a pilot in both cases. It also places the loops at opposite ends of the increment range. A design that subtracted with modular wrap would see them as close together and falsely detect.

Other tests cover the timing of each period. Periods of 0 and 1 are checked, as are period changes made mid-period; a design that reloaded the count early would close the period at the wrong cycle. Loop values are changed only in the last cycle of a period, to catch a design that samples too early. The bench also watches `detect` between period ends, to catch a verdict that leaks out before its valid pulse.

// File: rtl/pilot_seq_pkg.sv
package pilot_seq_pkg;

   // Shortest legal observation period in cycles.
   localparam int unsigned MIN_PERIOD = 2;

   // Final count value of a period, with short requests raised to the minimum.
   function automatic logic [63:0] period_last(input logic [63:0] req);
      logic [63:0] eff;
      eff = (req < 64'(MIN_PERIOD)) ? 64'(MIN_PERIOD) : req;
      return eff - 64'd1;
   endfunction

endpackage

// File: rtl/seq_preset_gen.sv
module seq_preset_gen #(
   parameter int unsigned INC_W = 24
) (
   input  logic [INC_W-1:0] pilot_inc,
   input  logic [INC_W-1:0] offset_inc,
   output logic [INC_W-1:0] hi_inc,
   output logic [INC_W-1:0] lo_inc
);
   // The increments are phase steps on a modular accumulator, so wrap is intended here.
   always_comb begin
      hi_inc = pilot_inc + offset_inc;
      lo_inc = pilot_inc - offset_inc;
   end
endmodule

// File: rtl/seq_period_timer.sv
module seq_period_timer
   import pilot_seq_pkg::*;
#(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cfg_period,
   output logic             preset,
   output logic             period_end
);
   logic             run_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_q;
   logic [CNT_W-1:0] last_req;

   always_comb begin
      last_req   = CNT_W'(period_last(64'(cfg_period)));
      preset     = run_q && (cnt_q == '0);
      period_end = run_q && (cnt_q != '0) && (cnt_q == last_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         cnt_q  <= '0;
         last_q <= CNT_W'(1);
      end else begin
         run_q <= 1'b1;
         if (preset) begin
            last_q <= last_req;
         end
         if (run_q) begin
            if (period_end) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/seq_conv_judge.sv
module seq_conv_judge #(
   parameter int unsigned INC_W            = 24,
   parameter bit          THRESH_INCLUSIVE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample,
   input  logic [INC_W-1:0] hi_inc,
   input  logic [INC_W-1:0] lo_inc,
   input  logic [INC_W-1:0] thresh,
   output logic             detect,
   output logic             detect_valid
);
   localparam int unsigned DW = INC_W + 1;

   logic signed [DW-1:0] diff;
   logic        [DW-1:0] mag;
   logic                 hit;

   always_comb begin
      diff = $signed({1'b0, hi_inc}) - $signed({1'b0, lo_inc});
      mag  = diff[DW-1] ? DW'(-diff) : DW'(diff);
   end

   generate
      if (THRESH_INCLUSIVE) begin : g_incl
         always_comb hit = (mag <= {1'b0, thresh});
      end else begin : g_strict
         always_comb hit = (mag < {1'b0, thresh});
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         detect       <= 1'b0;
         detect_valid <= 1'b0;
      end else begin
         detect_valid <= sample;
         if (sample) begin
            detect <= hit;
         end
      end
   end
endmodule

// File: rtl/pilot_conv_sequencer.sv
module pilot_conv_sequencer #(
   parameter int unsigned INC_W            = 24,
   parameter int unsigned CNT_W            = 24,
   parameter bit          THRESH_INCLUSIVE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INC_W-1:0] cfg_pilot_inc,
   input  logic [INC_W-1:0] cfg_offset_inc,
   input  logic [INC_W-1:0] cfg_thresh,
   input  logic [CNT_W-1:0] cfg_period,
   input  logic [INC_W-1:0] loop_hi_inc,
   input  logic [INC_W-1:0] loop_lo_inc,
   output logic             preset,
   output logic [INC_W-1:0] init_inc_hi,
   output logic [INC_W-1:0] init_inc_lo,
   output logic             detect,
   output logic             detect_valid
);
   generate
      if (INC_W < 4 || INC_W > 62) begin : g_bad_inc
         $error("INC_W must lie in 4..62");
      end
      if (CNT_W < 2 || CNT_W > 62) begin : g_bad_cnt
         $error("CNT_W must lie in 2..62");
      end
   endgenerate

   logic period_end;

   seq_preset_gen #(.INC_W(INC_W)) u_presets (
      .pilot_inc (cfg_pilot_inc),
      .offset_inc(cfg_offset_inc),
      .hi_inc    (init_inc_hi),
      .lo_inc    (init_inc_lo)
   );

   seq_period_timer #(.CNT_W(CNT_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_period(cfg_period),
      .preset    (preset),
      .period_end(period_end)
   );

   seq_conv_judge #(.INC_W(INC_W), .THRESH_INCLUSIVE(THRESH_INCLUSIVE)) u_judge (
      .clk         (clk),
      .rst_n       (rst_n),
      .sample      (period_end),
      .hi_inc      (loop_hi_inc),
      .lo_inc      (loop_lo_inc),
      .thresh      (cfg_thresh),
      .detect      (detect),
      .detect_valid(detect_valid)
   );
endmodule

// File: rtl/pilot_conv_checker.sv
module pilot_conv_checker #(
   parameter int unsigned INC_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic [INC_W-1:0] cfg_pilot_inc,
   input logic [INC_W-1:0] cfg_offset_inc,
   input logic [INC_W-1:0] cfg_thresh,
   input logic [INC_W-1:0] init_inc_hi,
   input logic [INC_W-1:0] init_inc_lo,
   input logic             preset,
   input logic             detect,
   input logic             detect_valid
);
   logic [INC_W-1:0] spread;
   logic [INC_W-1:0] twice_off;
   logic [INC_W-1:0] mid_sum;
   logic [INC_W-1:0] twice_pilot;

   always_comb begin
      spread      = init_inc_hi - init_inc_lo;
      twice_off   = cfg_offset_inc + cfg_offset_inc;
      mid_sum     = init_inc_hi + init_inc_lo;
      twice_pilot = cfg_pilot_inc + cfg_pilot_inc;
   end

   AST_PRESET_SPREAD: assert property (@(posedge clk) disable iff (!rst_n)
      spread == twice_off); // R1
   AST_PRESET_CENTRE: assert property (@(posedge clk) disable iff (!rst_n)
      mid_sum == twice_pilot); // R2
   AST_PRESET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      preset |=> !preset); // R3
   AST_VALID_WITH_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
      detect_valid |-> preset); // R8
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      detect_valid |=> !detect_valid); // R8
   AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !detect_valid |-> $stable(detect)); // R9
   AST_ZERO_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
      (detect_valid && $past(cfg_thresh) == '0) |-> !detect); // R7
endmodule

bind pilot_conv_sequencer pilot_conv_checker #(.INC_W(INC_W)) u_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .cfg_pilot_inc (cfg_pilot_inc),
   .cfg_offset_inc(cfg_offset_inc),
   .cfg_thresh    (cfg_thresh),
   .init_inc_hi   (init_inc_hi),
   .init_inc_lo   (init_inc_lo),
   .preset        (preset),
   .detect        (detect),
   .detect_valid  (detect_valid)
);

// File: tb/pilot_conv_sequencer_bench.sv
module pilot_conv_sequencer_bench;
   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned INC_W      = 24;
   localparam int unsigned CNT_W      = 24;

   typedef struct packed {
      logic [15:0]      per;
      logic [INC_W-1:0] pilot;
      logic [INC_W-1:0] off;
      logic [INC_W-1:0] thr;
      logic [INC_W-1:0] hi;
      logic [INC_W-1:0] lo;
      logic             exp_det;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{16'd4, 24'd1000,     24'd100, 24'd50,       24'd1100,     24'd900,      1'b0},
      '{16'd5, 24'd1000,     24'd100, 24'd50,       24'd1010,     24'd990,      1'b1},
      '{16'd3, 24'd1000,     24'd100, 24'd50,       24'd990,      24'd1010,     1'b1},
      '{16'd2, 24'd5000,     24'd300, 24'd50,       24'd5050,     24'd5000,     1'b0},
      '{16'd7, 24'd5000,     24'd300, 24'd50,       24'd5049,     24'd5000,     1'b1},
      '{16'd0, 24'd5000,     24'd300, 24'd1,        24'd777,      24'd777,      1'b1},
      '{16'd1, 24'd10,       24'd20,  24'd0,        24'd777,      24'd777,      1'b0},
      '{16'd6, 24'd10,       24'd20,  24'd100,      24'hFFFFF0,   24'h000010,   1'b0},
      '{16'd4, 24'hFFFFF0,   24'h20,  24'hFFFFFF,   24'hFFFFFF,   24'h000001,   1'b1},
      '{16'd3, 24'd1000,     24'd100, 24'd30,       24'd1000,     24'd1029,     1'b1}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [INC_W-1:0] cfg_pilot_inc = '0;
   logic [INC_W-1:0] cfg_offset_inc = '0;
   logic [INC_W-1:0] cfg_thresh = '0;
   logic [CNT_W-1:0] cfg_period = CNT_W'(4);
   logic [INC_W-1:0] loop_hi_inc = '0;
   logic [INC_W-1:0] loop_lo_inc = '0;
   logic             preset;
   logic [INC_W-1:0] init_inc_hi;
   logic [INC_W-1:0] init_inc_lo;
   logic             detect;
   logic             detect_valid;

   int  total = 0;
   int  bad   = 0;
   bit  done  = 1'b0;
   logic held_det = 1'b0;

   pilot_conv_sequencer #(.INC_W(INC_W), .CNT_W(CNT_W)) u_pilot_conv_sequencer (
      .clk           (clk),
      .rst_n         (rst_n),
      .cfg_pilot_inc (cfg_pilot_inc),
      .cfg_offset_inc(cfg_offset_inc),
      .cfg_thresh    (cfg_thresh),
      .cfg_period    (cfg_period),
      .loop_hi_inc   (loop_hi_inc),
      .loop_lo_inc   (loop_lo_inc),
      .preset        (preset),
      .init_inc_hi   (init_inc_hi),
      .init_inc_lo   (init_inc_lo),
      .detect        (detect),
      .detect_valid  (detect_valid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Walk one period from its preset cycle. Loop values are held unless late_hi/late_lo are applied in the last cycle.
   task automatic run_period(input int eff, input logic exp_det,
                             input bit use_late, input logic [INC_W-1:0] late_hi,
                             input logic [INC_W-1:0] late_lo);
      for (int k = 1; k < eff; k++) begin
         @(negedge clk);
         check("R3", "preset mid-period", 64'(preset), 64'd0);
         check("R8", "valid mid-period", 64'(detect_valid), 64'd0);
         check("R9", "verdict held", 64'(detect), 64'(held_det));
         if (use_late && k == eff - 1) begin
            loop_hi_inc = late_hi;
            loop_lo_inc = late_lo;
         end
      end
      @(negedge clk);
      check("R8", "valid at period end", 64'(detect_valid), 64'd1);
      check("R3", "preset at period start", 64'(preset), 64'd1);
      check("R6", "verdict", 64'(detect), 64'(exp_det));
      held_det = exp_det;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R10: outputs quiet under reset
      repeat (3) @(negedge clk);
      check("R10", "preset in reset", 64'(preset), 64'd0);
      check("R10", "valid in reset", 64'(detect_valid), 64'd0);
      check("R10", "detect in reset", 64'(detect), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R3", "preset after reset release", 64'(preset), 64'd1);

      // Vector table walk
      for (int i = 0; i < NV; i++) begin
         int eff;
         cfg_period     = CNT_W'(VECS[i].per);
         cfg_pilot_inc  = VECS[i].pilot;
         cfg_offset_inc = VECS[i].off;
         cfg_thresh     = VECS[i].thr;
         loop_hi_inc    = VECS[i].hi;
         loop_lo_inc    = VECS[i].lo;
         #1;
         check("R1", "upper initial increment", 64'(init_inc_hi),
               64'(INC_W'(VECS[i].pilot + VECS[i].off)));
         check("R2", "lower initial increment", 64'(init_inc_lo),
               64'(INC_W'(VECS[i].pilot - VECS[i].off)));
         eff = (VECS[i].per < 16'd2) ? 2 : int'(VECS[i].per);
         run_period(eff, VECS[i].exp_det, 1'b0, '0, '0);   // R4 R6 R7
      end

      // R5: a period change after the preset cycle waits for the next period
      cfg_period  = CNT_W'(6);
      cfg_thresh  = 24'd10;
      loop_hi_inc = 24'd500;
      loop_lo_inc = 24'd503;
      @(negedge clk);
      check("R3", "no preset at cycle one", 64'(preset), 64'd0);
      cfg_period = CNT_W'(3);
      for (int k = 2; k < 6; k++) begin
         @(negedge clk);
         check("R5", "period not shortened", 64'(detect_valid), 64'd0);
      end
      @(negedge clk);
      check("R5", "end at original length", 64'(detect_valid), 64'd1);
      check("R6", "verdict after long period", 64'(detect), 64'd1);
      held_det = 1'b1;

      // Now the period of 3 applies
      run_period(3, 1'b1, 1'b0, '0, '0);   // R4

      // R6: only the last cycle's loop values count (far apart, then close)
      cfg_period  = CNT_W'(5);
      loop_hi_inc = 24'd9000;
      loop_lo_inc = 24'd100;
      run_period(5, 1'b1, 1'b1, 24'd2000, 24'd2005);
      // R6: close until the last cycle, then far apart
      loop_hi_inc = 24'd2000;
      loop_lo_inc = 24'd2001;
      run_period(5, 1'b0, 1'b1, 24'd4000, 24'd2000);
      // R9: verdict of 1 held while loops separate mid-period
      loop_hi_inc = 24'd2000;
      loop_lo_inc = 24'd2001;
      run_period(5, 1'b1, 1'b0, '0, '0);
      loop_hi_inc = 24'd9999;
      @(negedge clk);
      check("R9", "verdict held after input move", 64'(detect), 64'd1);

      // R10: reset mid-run clears the verdict
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R10", "detect cleared by reset", 64'(detect), 64'd0);
      check("R10", "preset low in reset", 64'(preset), 64'd0);
      check("R10", "valid low in reset", 64'(detect_valid), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R3", "preset after second release", 64'(preset), 64'd1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule